// File: doc/BRIEF.md
# Parity-Preserving Reversible Carry-Skip Adder

This block adds two 4-bit operands and a carry-in using only reversible, parity-preserving gates. Each bit position is a fault-tolerant full-adder cell. The cell is built from two-target controlled-XOR gates (one control, two XOR targets) and a controlled-swap gate. The cells form a ripple chain. A bypass network made of controlled-swap gates ANDs the four per-bit propagate terms. When every position propagates, the network routes the incoming carry straight to the carry-out. A two-target controlled-XOR gate at the input splits the carry-in into one copy for the chain and one for the bypass. A second such gate at the output drives the carry-out. As a result, no line fans out more than once.

Every gate keeps the XOR of its outputs equal to the XOR of its inputs. Zero ancillas do not affect that XOR. The XOR of all primary inputs must therefore equal the XOR of all terminal lines: the sum bits, the carry-out and the garbage lines. The block compares the two and raises a flag on any mismatch. A fault-mask input flips chosen terminal lines, so that single-line upsets can be injected and their detection observed. The block is purely combinational.

Top module: `rft_skip_adder`

## Requirements
- R1: With `fault_mask` all zero, `sum` equals the low 4 bits of x + y + cin for every one of the 512 input combinations.
- R2: With `fault_mask` all zero, `cout` equals bit 4 of x + y + cin for every input combination.
- R3: When x XOR y is all ones (every position propagates), `cout` equals `cin` through the bypass path. Otherwise `cout` equals the carry rippled out of the top cell.
- R4: With `fault_mask` all zero, `par_err` is 0 for every input combination, because each gate preserves parity.
- R5: Terminal line k is flipped when `fault_mask[k]` is 1. Lines 0 to 3 are `sum[3:0]`, line 4 is `cout`, and lines 5 to 23 are `junk[18:0]`. A single set mask bit flips exactly that output bit and sets `par_err` to 1.
- R6: For any mask, `par_err` equals the XOR reduction of `fault_mask`. An odd number of flipped lines is flagged and an even number is not.
- R7: `junk` has 4*W+3 = 19 lines, so primary inputs plus zero ancillas (24 lines) equal terminal lines (24 lines), as reversibility requires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x | input | 4 | First operand |
| y | input | 4 | Second operand |
| cin | input | 1 | Carry-in |
| fault_mask | input | 24 | Per-line flip mask for injected upsets (bit k flips terminal line k) |
| sum | output | 4 | Sum bits |
| cout | output | 1 | Carry-out |
| junk | output | 19 | Garbage lines of the reversible network |
| par_err | output | 1 | High when output-line parity differs from input parity |

## Verification
The arithmetic assertions and the clean-parity assertions assume an all-zero fault mask. Only the parity-equals-mask relation is checked for any mask. The stimulus runs the full 512-combination sweep and the directed bypass cases with the mask cleared. Single-bit and multi-bit masks are applied only in separate phases, where the bench computes the expected flipped outputs itself. In the cells and the bypass network, the assertions see only internal lines that never pass through the mask, so they hold for every stimulus.

// File: rtl/rft_pkg.sv
package rft_pkg;

  typedef struct packed {
    logic o0;
    logic o1;
    logic o2;
  } rgate_t;

  // two-target controlled XOR: control passes, each target XORed with control
  function automatic rgate_t dcx(input logic c, input logic t1, input logic t2);
    rgate_t r;
    r.o0 = c;
    r.o1 = c ^ t1;
    r.o2 = c ^ t2;
    return r;
  endfunction

  // controlled swap: data lines exchange when control is one
  function automatic rgate_t cswap(input logic c, input logic d1, input logic d2);
    rgate_t r;
    r.o0 = c;
    r.o1 = c ? d2 : d1;
    r.o2 = c ? d1 : d2;
    return r;
  endfunction

endpackage

// File: rtl/rft_fa_cell.sv
module rft_fa_cell
  import rft_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co,
  output logic p,
  output logic g0,
  output logic g1
);

  rgate_t st1, st2, st3, st4;

  always_comb begin
    st1 = dcx(a, b, 1'b0);               // a, a^b, copy of a
    st2 = dcx(ci, 1'b0, st1.o0);         // ci, copy of ci, a^ci
    st3 = cswap(st1.o1, st1.o2, st2.o0); // propagate selects a or ci as carry
    st4 = dcx(st3.o0, st2.o1, st2.o2);   // propagate, sum, b^ci
  end

  assign p  = st4.o0;
  assign s  = st4.o1;
  assign co = st3.o1;
  assign g0 = st4.o2;
  assign g1 = st3.o2;

  always_comb begin
    ap_cell_add_r1: assert ({co, s} == 2'(a) + 2'(b) + 2'(ci))
      else $error("cell add mismatch");
    ap_cell_parity_r4: assert ((a ^ b ^ ci) == (s ^ co ^ p ^ g0 ^ g1))
      else $error("cell parity mismatch");
  end

endmodule

// File: rtl/rft_skip_net.sv
module rft_skip_net
  import rft_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]   prop,
  input  logic           c_rip,
  input  logic           c_in,
  output logic           c_sel,
  output logic [2*W-1:0] junk
);

  logic [W-1:0] and_t;
  rgate_t       mx;

  assign and_t[0] = prop[0];

  for (genvar i = 1; i < W; i++) begin : g_and
    rgate_t fr;
    always_comb fr = cswap(prop[i], and_t[i-1], 1'b0);
    assign and_t[i]        = fr.o2;
    assign junk[2*(i-1)]   = fr.o0;
    assign junk[2*(i-1)+1] = fr.o1;
  end

  always_comb mx = cswap(and_t[W-1], c_rip, c_in);

  assign c_sel        = mx.o1;
  assign junk[2*W-2]  = mx.o0;
  assign junk[2*W-1]  = mx.o2;

  always_comb begin
    if (&prop) begin
      ap_skip_bypass_r3: assert (c_sel == c_in) else $error("bypass not taken");
    end else begin
      ap_skip_ripple_r3: assert (c_sel == c_rip) else $error("ripple carry lost");
    end
    ap_skip_parity_r4: assert ((^prop ^ c_rip ^ c_in) == (c_sel ^ ^junk))
      else $error("skip parity mismatch");
  end

endmodule

// File: rtl/rft_skip_adder.sv
module rft_skip_adder
  import rft_pkg::*;
#(
  parameter int W = 4,
  localparam int NJUNK = 4*W + 3,
  localparam int NLINE = W + 1 + NJUNK
) (
  input  logic [W-1:0]     x,
  input  logic [W-1:0]     y,
  input  logic             cin,
  input  logic [NLINE-1:0] fault_mask,
  output logic [W-1:0]     sum,
  output logic             cout,
  output logic [NJUNK-1:0] junk,
  output logic             par_err
);

  rgate_t cin_split, cout_drv;
  logic [W:0]       carry;
  logic [W-1:0]     sum_raw, prop, cg0, cg1;
  logic [2*W-1:0]   skip_junk;
  logic             c_sel;
  logic [NJUNK-1:0] junk_raw;
  logic [NLINE-1:0] line_raw, line_out;
  logic [W:0]       ref_add;

  always_comb cin_split = dcx(cin, 1'b0, 1'b0);
  assign carry[0] = cin_split.o0;

  for (genvar i = 0; i < W; i++) begin : g_cell
    rft_fa_cell u_cell (
      .a  (x[i]),
      .b  (y[i]),
      .ci (carry[i]),
      .s  (sum_raw[i]),
      .co (carry[i+1]),
      .p  (prop[i]),
      .g0 (cg0[i]),
      .g1 (cg1[i])
    );
  end

  rft_skip_net #(.W(W)) u_skip (
    .prop  (prop),
    .c_rip (carry[W]),
    .c_in  (cin_split.o1),
    .c_sel (c_sel),
    .junk  (skip_junk)
  );

  always_comb cout_drv = dcx(c_sel, 1'b0, 1'b0);

  assign junk_raw = {cin_split.o2, cout_drv.o2, cout_drv.o1, skip_junk, cg1, cg0};
  assign line_raw = {junk_raw, cout_drv.o0, sum_raw};
  assign line_out = line_raw ^ fault_mask;

  assign sum     = line_out[W-1:0];
  assign cout    = line_out[W];
  assign junk    = line_out[NLINE-1:W+1];
  assign par_err = (^x ^ ^y ^ cin) ^ (^line_out);

  assign ref_add = {1'b0, x} + {1'b0, y} + (W+1)'(cin);

  always_comb begin
    if (fault_mask == '0) begin
      ap_sum_r1: assert (sum == ref_add[W-1:0]) else $error("sum wrong");
      ap_cout_r2: assert (cout == ref_add[W]) else $error("cout wrong");
      ap_par_clean_r4: assert (!par_err) else $error("false parity alarm");
    end
    ap_par_mask_r6: assert (par_err == ^fault_mask) else $error("parity flag vs mask");
  end

endmodule

// File: tb/rft_skip_adder_bench.sv
module rft_skip_adder_bench;

  localparam int W = 4;
  localparam int NJUNK = 4*W + 3;
  localparam int NLINE = W + 1 + NJUNK;

  logic clk;
  logic rst_n;
  logic [W-1:0] x, y;
  logic cin;
  logic [NLINE-1:0] fault_mask;
  logic [W-1:0] sum;
  logic cout;
  logic [NJUNK-1:0] junk;
  logic par_err;

  int n_run;
  int n_fail;

  rft_skip_adder u_rft_skip_adder (
    .x(x), .y(y), .cin(cin), .fault_mask(fault_mask),
    .sum(sum), .cout(cout), .junk(junk), .par_err(par_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [W:0] ref_total(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic c);
    return {1'b0, a} + {1'b0, b} + (W+1)'(c);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (x=%0h y=%0h cin=%0b mask=%0h)",
               req, act, exp, x, y, cin, fault_mask);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                       input logic [NLINE-1:0] m);
    @(posedge clk);
    x = a; y = b; cin = c; fault_mask = m;
    @(negedge clk);
  endtask

  task automatic finish_up;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [W:0] t;
    logic [NLINE-1:0] m;
    logic [NLINE-1:0] clean;
    n_run = 0; n_fail = 0;
    rst_n = 1'b0;
    x = '0; y = '0; cin = 1'b0; fault_mask = '0;
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset-time state with all inputs low
    chk("R1 idle sum", 32'(sum), 32'h0);
    chk("R2 idle cout", 32'(cout), 32'h0);
    chk("R4 idle parity", 32'(par_err), 32'h0);
    chk("R7 junk width", 32'($bits(junk)), 32'd19);

    // exhaustive sweep, clean mask
    for (int v = 0; v < 512; v++) begin
      apply(v[3:0], v[7:4], v[8], '0);
      t = ref_total(v[3:0], v[7:4], v[8]);
      chk("R1 sum", 32'(sum), 32'(t[W-1:0]));
      chk("R2 cout", 32'(cout), 32'(t[W]));
      chk("R4 clean parity", 32'(par_err), 32'h0);
    end

    // bypass corner cases: full propagate, cout follows cin
    apply(4'b1010, 4'b0101, 1'b0, '0); chk("R3 bypass cin=0", 32'(cout), 32'h0);
    apply(4'b1010, 4'b0101, 1'b1, '0); chk("R3 bypass cin=1", 32'(cout), 32'h1);
    apply(4'b1111, 4'b0000, 1'b1, '0); chk("R3 bypass all-ones", 32'(cout), 32'h1);
    apply(4'b0000, 4'b1111, 1'b0, '0); chk("R3 bypass zero", 32'(cout), 32'h0);
    // one non-propagating position: carry comes from ripple
    apply(4'b1011, 4'b0101, 1'b0, '0); chk("R3 ripple generate", 32'(cout), 32'h1);
    apply(4'b0010, 4'b0101, 1'b1, '0); chk("R3 ripple kill", 32'(cout), 32'h0);

    // single-line injected faults
    for (int k = 0; k < 240; k++) begin
      logic [W-1:0] a, b;
      logic c;
      int line;
      a = W'($urandom); b = W'($urandom); c = 1'($urandom);
      line = (k < NLINE) ? k : int'($urandom % NLINE);
      m = '0; m[line] = 1'b1;
      apply(a, b, c, '0);
      clean = {junk, cout, sum};
      apply(a, b, c, m);
      t = ref_total(a, b, c);
      chk("R5 fault flagged", 32'(par_err), 32'h1);
      chk("R5 flipped sum", 32'(sum), 32'(t[W-1:0] ^ m[W-1:0]));
      chk("R5 flipped cout", 32'(cout), 32'(t[W] ^ m[W]));
      chk("R5 flipped junk", 32'(junk), 32'(clean[NLINE-1:W+1] ^ m[NLINE-1:W+1]));
    end

    // multi-line masks: odd count flagged, even count hidden
    for (int k = 0; k < 200; k++) begin
      m = NLINE'($urandom);
      if (k == 0) m = 24'h000003;
      if (k == 1) m = 24'h000007;
      apply(W'($urandom), W'($urandom), 1'($urandom), m);
      chk("R6 parity vs mask", 32'(par_err), 32'(^m));
    end

    finish_up();
  end

endmodule